// File: doc/BRIEF.md
# Age-Ordered Instruction Issue Queue

This block holds instructions between dispatch and write-back. Each accepted instruction takes one of a fixed number of slots and passes through three states: waiting for its inputs, ready to issue, and executing. Dispatch supplies the instruction's sequence index, a flag saying its inputs are already satisfied, and its execution latency. Two per-slot wakeup vectors, one for register operands and one for memory dependencies, release waiting entries. An entry needs both before it becomes ready, and it becomes ready at the next clock edge.

Each cycle the queue offers the oldest ready entry on an issue handshake. Age is judged by sequence index with wrap-around-safe subtraction. An issued entry counts its latency down and then reports completion, which frees its slot. A zero-latency instruction whose inputs are ready can issue in the same cycle it is dispatched, provided the issue side accepts and no queued entry is ready. When every slot is occupied, dispatch is refused and a stall is flagged.

Top module: `issue_queue`

## Requirements
- R1: After reset, `issue_valid` and `done_valid` are low and `disp_ready` is high.
- R2: An instruction accepted in cycle c with `disp_opnd_rdy` high becomes ready at the next edge and can issue in cycle c+1. This does not apply when it takes the bypass of R7.
- R3: An instruction accepted with `disp_opnd_rdy` low stays waiting until both `wake_opnd[s]` and `wake_mem[s]` have been seen high for its slot s, in the same cycle or in different cycles. It can issue no earlier than the cycle after the later of the two wakeups.
- R4: Among ready entries, the one with the oldest index issues first. Index a is older than b when bit IDX_W-1 of (a - b) modulo 2^IDX_W is 1.
- R5: While `issue_valid` is high and `issue_ready` is low, `issue_valid` stays high and nothing is consumed. An entry issued with `issue_valid && issue_ready` is never offered again.
- R6: An entry issued in cycle t with latency L raises `done_valid` with its index in cycle t+1+L. If several entries have finished, one is reported per cycle, oldest first. A reported slot is freed at that edge.
- R7: An accepted instruction with latency 0 and `disp_opnd_rdy` high issues in the same cycle (`issue_idx` = `disp_idx`) when `issue_ready` is high and no queued entry is ready. Its completion follows in the next cycle. If a queued entry is ready, the new instruction enters the ready state instead.
- R8: When all DEPTH slots are occupied, `disp_ready` is low, `disp_stall` follows `disp_valid`, and the offered instruction is dropped and never issues.
- R9: `disp_slot` gives the lowest-numbered free slot, and an accepted instruction is placed there. Bit s of each wakeup vector applies to slot s only while that slot is waiting. At any other time the bit has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | IDX_W | Sequence index of the dispatched instruction |
| disp_opnd_rdy | input | 1 | Operands and memory dependencies already satisfied |
| disp_lat | input | LAT_W | Execution latency in cycles |
| disp_ready | output | 1 | A free slot exists; dispatch is accepted |
| disp_stall | output | 1 | Dispatch offered but refused |
| disp_slot | output | $clog2(DEPTH) | Slot an accepted instruction will occupy |
| wake_opnd | input | DEPTH | Per-slot register operand wakeup |
| wake_mem | input | DEPTH | Per-slot memory dependency wakeup |
| issue_valid | output | 1 | An instruction is offered for issue |
| issue_ready | input | 1 | Execution resources accept the offer |
| issue_idx | output | IDX_W | Index of the offered instruction |
| done_valid | output | 1 | An instruction reached write-back |
| done_idx | output | IDX_W | Index of the completed instruction |

## Verification
The bench builds the queue with DEPTH = 4, IDX_W = 4 and LAT_W = 3. Four slots fill after four dispatches, so the full-queue refusal is reached within a few cycles. A 4-bit index wraps after 15, which puts indices 14, 15, 0 and 1 in the queue together and checks that age ordering crosses the wrap point. Latencies up to 7 are enough to make two entries finish in the same cycle and so exercise completion ordering.

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 8,
  parameter int LAT_W = 4,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [IDX_W-1:0]  disp_idx,
  input  logic              disp_opnd_rdy,
  input  logic [LAT_W-1:0]  disp_lat,
  output logic              disp_ready,
  output logic              disp_stall,
  output logic [SLOT_W-1:0] disp_slot,
  input  logic [DEPTH-1:0]  wake_opnd,
  input  logic [DEPTH-1:0]  wake_mem,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [IDX_W-1:0]  issue_idx,
  output logic              done_valid,
  output logic [IDX_W-1:0]  done_idx
);

  typedef enum logic [1:0] {S_FREE, S_WAIT, S_READY, S_EXEC} st_t;

  st_t              st_q   [DEPTH];
  logic [IDX_W-1:0] idx_q  [DEPTH];
  logic [LAT_W-1:0] cnt_q  [DEPTH];
  logic             opnd_q [DEPTH];
  logic             mem_q  [DEPTH];

  logic              full, rdy_any, fin_any;
  logic [SLOT_W-1:0] alloc, rdy_sel, fin_sel;
  logic [DEPTH-1:0]  occ;

  function automatic logic older(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
    logic [IDX_W-1:0] d;
    d = a - b;
    return d[IDX_W-1];
  endfunction

  always_comb begin
    full    = 1'b1;
    alloc   = '0;
    rdy_any = 1'b0;
    rdy_sel = '0;
    fin_any = 1'b0;
    fin_sel = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (st_q[i] == S_FREE) begin
        full  = 1'b0;
        alloc = SLOT_W'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      occ[i] = (st_q[i] != S_FREE);
      if (st_q[i] == S_READY && (!rdy_any || older(idx_q[i], idx_q[rdy_sel]))) begin
        rdy_any = 1'b1;
        rdy_sel = SLOT_W'(i);
      end
      if (st_q[i] == S_EXEC && cnt_q[i] == '0 && (!fin_any || older(idx_q[i], idx_q[fin_sel]))) begin
        fin_any = 1'b1;
        fin_sel = SLOT_W'(i);
      end
    end
  end

  logic accept, bypass, q_fire;
  assign accept      = disp_valid && !full;
  assign bypass      = accept && disp_opnd_rdy && disp_lat == '0 && !rdy_any && issue_ready;
  assign q_fire      = rdy_any && issue_ready;
  assign disp_ready  = !full;
  assign disp_stall  = disp_valid && full;
  assign disp_slot   = alloc;
  assign issue_valid = rdy_any || bypass;
  assign issue_idx   = rdy_any ? idx_q[rdy_sel] : disp_idx;
  assign done_valid  = fin_any;
  assign done_idx    = idx_q[fin_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= S_FREE;
        idx_q[i]  <= '0;
        cnt_q[i]  <= '0;
        opnd_q[i] <= 1'b0;
        mem_q[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        case (st_q[i])
          S_FREE: if (accept && alloc == SLOT_W'(i)) begin
            idx_q[i]  <= disp_idx;
            cnt_q[i]  <= disp_lat;
            opnd_q[i] <= disp_opnd_rdy;
            mem_q[i]  <= disp_opnd_rdy;
            st_q[i]   <= bypass ? S_EXEC : (disp_opnd_rdy ? S_READY : S_WAIT);
          end
          S_WAIT: begin
            opnd_q[i] <= opnd_q[i] || wake_opnd[i];
            mem_q[i]  <= mem_q[i] || wake_mem[i];
            if ((opnd_q[i] || wake_opnd[i]) && (mem_q[i] || wake_mem[i]))
              st_q[i] <= S_READY;
          end
          S_READY: if (q_fire && rdy_sel == SLOT_W'(i)) st_q[i] <= S_EXEC;
          S_EXEC: begin
            if (cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;
            else if (fin_sel == SLOT_W'(i)) st_q[i] <= S_FREE;
          end
          default: st_q[i] <= S_FREE;
        endcase
      end
    end
  end

  p_ready_dispatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && disp_opnd_rdy && !bypass) |=> st_q[$past(alloc)] == S_READY);

  p_wait_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !disp_opnd_rdy) |=> st_q[$past(alloc)] == S_WAIT);

  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> issue_valid);

  p_issue_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_fire |=> st_q[$past(rdy_sel)] == S_EXEC);

  p_done_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> st_q[$past(fin_sel)] == S_FREE);

  p_refuse_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> $countones(occ) <= $past($countones(occ)));

endmodule

// File: tb/issue_queue_test.sv
module issue_queue_test;
  localparam int DEPTH = 4;
  localparam int IDX_W = 4;
  localparam int LAT_W = 3;

  typedef struct {
    int    idx;
    int    cyc;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [IDX_W-1:0] disp_idx = '0;
  logic disp_opnd_rdy = 1'b0;
  logic [LAT_W-1:0] disp_lat = '0;
  logic disp_ready, disp_stall;
  logic [1:0] disp_slot;
  logic [DEPTH-1:0] wake_opnd = '0;
  logic [DEPTH-1:0] wake_mem = '0;
  logic issue_valid;
  logic issue_ready = 1'b1;
  logic [IDX_W-1:0] issue_idx;
  logic done_valid;
  logic [IDX_W-1:0] done_idx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  item_t exp_issue[$];
  item_t exp_done[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  issue_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LAT_W(LAT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_opnd_rdy(disp_opnd_rdy), .disp_lat(disp_lat),
    .disp_ready(disp_ready), .disp_stall(disp_stall), .disp_slot(disp_slot),
    .wake_opnd(wake_opnd), .wake_mem(wake_mem),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_idx(issue_idx),
    .done_valid(done_valid), .done_idx(done_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_issue(input int idx, input int c, input string req);
    exp_issue.push_back('{idx: idx, cyc: c, req: req});
  endtask

  task automatic push_done(input int idx, input int c, input string req);
    exp_done.push_back('{idx: idx, cyc: c, req: req});
  endtask

  task automatic disp(input int idx, input bit rdy, input int lat);
    disp_valid    = 1'b1;
    disp_idx      = IDX_W'(idx);
    disp_opnd_rdy = rdy;
    disp_lat      = LAT_W'(lat);
    tick();
    disp_valid    = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (issue_valid && issue_ready) begin
        if (exp_issue.size() == 0) begin
          check(1'b0, "R8 unexpected issue", int'(issue_idx), -1);
        end else begin
          item_t e;
          e = exp_issue.pop_front();
          check(int'(issue_idx) == e.idx && cyc == e.cyc, {e.req, " issue idx"}, int'(issue_idx), e.idx);
          check(cyc == e.cyc, {e.req, " issue cycle"}, cyc, e.cyc);
        end
      end
      if (done_valid) begin
        if (exp_done.size() == 0) begin
          check(1'b0, "R6 unexpected completion", int'(done_idx), -1);
        end else begin
          item_t e;
          e = exp_done.pop_front();
          check(int'(done_idx) == e.idx, {e.req, " done idx"}, int'(done_idx), e.idx);
          check(cyc == e.cyc, {e.req, " done cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!issue_valid, "R1 issue_valid", int'(issue_valid), 0);
    check(!done_valid, "R1 done_valid", int'(done_valid), 0);
    check(disp_ready, "R1 disp_ready", int'(disp_ready), 1);
    tick();

    // R2 / R6: single ready instruction, latency 2
    c = cyc;
    push_issue(1, c + 1, "R2");
    push_done(1, c + 4, "R6");
    disp(1, 1'b1, 2);
    repeat (8) tick();

    // R6: two entries finish together, oldest reported first
    c = cyc;
    push_issue(6, c + 1, "R6");
    push_issue(5, c + 2, "R6");
    push_done(5, c + 4, "R6");
    push_done(6, c + 5, "R6");
    disp(6, 1'b1, 2);
    disp(5, 1'b1, 1);
    repeat (8) tick();

    // R4 / R5 / R8: fill while blocked, wrap-around ordering
    issue_ready = 1'b0;
    c = cyc;
    push_issue(14, c + 5, "R4");
    push_issue(15, c + 6, "R4");
    push_issue(0, c + 7, "R4");
    push_issue(1, c + 8, "R4");
    push_done(14, c + 7, "R6");
    push_done(15, c + 8, "R6");
    push_done(0, c + 9, "R6");
    push_done(1, c + 10, "R6");
    disp(1, 1'b1, 1);
    disp(0, 1'b1, 1);
    disp(15, 1'b1, 1);
    disp(14, 1'b1, 1);
    disp_valid = 1'b1;
    disp_idx = 4'd5;
    disp_opnd_rdy = 1'b1;
    disp_lat = '0;
    @(negedge clk);
    check(!disp_ready, "R8 disp_ready when full", int'(disp_ready), 0);
    check(disp_stall, "R8 disp_stall when full", int'(disp_stall), 1);
    check(issue_valid, "R5 offer held", int'(issue_valid), 1);
    check(issue_idx == 4'd14, "R4 oldest across wrap", int'(issue_idx), 14);
    tick();
    disp_valid = 1'b0;
    issue_ready = 1'b1;
    repeat (10) tick();

    // R3 / R9: wakeup handling
    c = cyc;
    push_issue(3, c + 3, "R3");
    push_done(3, c + 4, "R3");
    push_issue(4, c + 6, "R9");
    push_done(4, c + 7, "R9");
    disp_valid = 1'b1; disp_idx = 4'd3; disp_opnd_rdy = 1'b0; disp_lat = '0;
    @(negedge clk);
    check(disp_slot == 2'd0, "R9 lowest free slot", int'(disp_slot), 0);
    tick();
    disp_idx = 4'd4;
    wake_opnd = 4'b0001;
    wake_mem = 4'b0010;
    @(negedge clk);
    check(disp_slot == 2'd1, "R9 next free slot", int'(disp_slot), 1);
    tick();
    disp_valid = 1'b0;
    wake_opnd = 4'b0010;
    wake_mem = 4'b0001;
    @(negedge clk);
    check(!issue_valid, "R3 no issue in promotion cycle", int'(issue_valid), 0);
    tick();
    wake_opnd = '0;
    wake_mem = '0;
    tick();
    @(negedge clk);
    check(!issue_valid, "R9 wake to free slot ignored", int'(issue_valid), 0);
    tick();
    wake_mem = 4'b0010;
    @(negedge clk);
    check(!issue_valid, "R3 waits for both wakeups", int'(issue_valid), 0);
    tick();
    wake_mem = '0;
    repeat (6) tick();

    // R7: zero-latency bypass, then bypass blocked by a ready entry
    c = cyc;
    push_issue(8, c, "R7");
    push_done(8, c + 1, "R7");
    push_issue(9, c + 3, "R7");
    push_issue(10, c + 4, "R7");
    push_done(10, c + 5, "R7");
    push_done(9, c + 7, "R7");
    disp_valid = 1'b1; disp_idx = 4'd8; disp_opnd_rdy = 1'b1; disp_lat = '0;
    @(negedge clk);
    check(issue_valid && issue_idx == 4'd8, "R7 same-cycle bypass", int'(issue_idx), 8);
    tick();
    disp_valid = 1'b0;
    tick();
    disp(9, 1'b1, 3);
    disp(10, 1'b1, 0);
    repeat (8) tick();

    check(exp_issue.size() == 0, "R5 pending issues", exp_issue.size(), 0);
    check(exp_done.size() == 0, "R6 pending completions", exp_done.size(), 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule